// File: doc/BRIEF.md
# Host Interrupt Status and Coalescing Unit

This block gathers single-cycle event pulses from the rest of the chip into two write-1-to-clear status registers. The main status register holds general events. The DMA status register holds per-channel transfer events. Three bits of the main register are not stored. They are live summaries of the DMA register: receive activity, transmit activity and DMA error. An enable mask selects which main bits may raise the single host interrupt line.

Coalescing reduces the host interrupt rate. Once an enabled event is pending, the line is held back for a programmed number of time units. A prescaler turns clock cycles into those units. A coalescing value of zero gives no delay. A high-priority receive event in the DMA register also skips the delay, provided the receive summary is enabled. The host services the interrupt by reading the status and writing ones to clear the bits it has handled.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset all four registers read 0 and `irq_o` is low.
- R2: A pulse on `evt_main_i` sets its main status bit for every bit except 31, 29 and 27. The bit stays set until the host writes 1 to it at address 0. Writing 0 to it changes nothing.
- R3: If an event pulse and a write-1 clear hit the same bit in the same cycle, the bit is set afterwards.
- R4: DMA status (address 2) holds only these bits: 31 error, 30 high-priority receive, 17 and 16 receive channels 1 and 0, 1 and 0 transmit channels 1 and 0. Each is set by `evt_dma_i` and cleared by writing 1. All other bits read 0.
- R5: Main bit 31 reads as the OR of DMA bits 30, 17 and 16. Main bit 27 reads as the OR of DMA bits 1 and 0. Main bit 29 reads as DMA bit 31. Writes and event pulses aimed at these three main bits have no effect.
- R6: `irq_o` is high only while some main status bit and its mask bit (address 1) are both 1. An event whose mask bit is 0 never raises `irq_o`.
- R7: With coalescing value 0, `irq_o` rises one cycle after an enabled status bit becomes visible.
- R8: With coalescing value N > 0, `irq_o` rises N×UNIT_CYCLES+1 cycles after an enabled status bit becomes visible.
- R9: If DMA bit 30 is set and mask bit 31 is set, `irq_o` rises one cycle later, whatever the coalescing value.
- R10: Once high, `irq_o` stays high until no enabled main bit remains set. It drops in the cycle after the clearing write or mask change.
- R11: Register map: 0 main status, 1 mask, 2 DMA status, 3 coalescing value (COAL_W bits, upper bits read 0). Read data is combinational on the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_main_i | input | 32 | Single-cycle event pulses for the main status bits |
| evt_dma_i | input | 32 | Single-cycle event pulses for the DMA status bits |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data (ones clear status bits) |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Host interrupt line |

## Verification
The bench tries the interrupt path with several patterns:
- A lone enabled event at zero coalescing, to measure the base latency.
- The same event under a nonzero coalescing value, so that an off-by-one in the unit count or the prescaler shows up as a shifted rising edge.
- A masked event, which must not raise the line.
- A high-priority receive event under a nonzero delay, which separates the bypass from the normal timer.
- An acknowledge that lands on the same cycle as a new event, which tells whether the set or the clear wins.

DMA channel events are checked through the summary bits, and writes aimed at those summary bits are checked to have no effect.

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl #(
  parameter int UNIT_CYCLES = 6400,
  parameter int COAL_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_main_i,
  input  logic [31:0] evt_dma_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int          PRE_W    = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);
  localparam logic [31:0] SUM_BITS = 32'hA800_0000;
  localparam logic [31:0] DMA_IMPL = 32'hC003_0003;
  localparam logic [31:0] DMA_RX   = 32'h4003_0000;
  localparam logic [31:0] DMA_TX   = 32'h0000_0003;

  logic [31:0]       stat_q, dma_q, mask_q;
  logic [COAL_W-1:0] coal_q, left_q;
  logic [PRE_W-1:0]  pre_q;
  logic              armed_q, run_q;

  wire wr_main = reg_wr_i && (reg_addr_i == 2'd0);
  wire wr_mask = reg_wr_i && (reg_addr_i == 2'd1);
  wire wr_dma  = reg_wr_i && (reg_addr_i == 2'd2);
  wire wr_coal = reg_wr_i && (reg_addr_i == 2'd3);

  wire [31:0] sum_vec = {(|(dma_q & DMA_RX)), 1'b0, dma_q[31], 1'b0, (|(dma_q & DMA_TX)), 27'b0};
  wire [31:0] main_view = stat_q | sum_vec;
  wire        pend = |(main_view & mask_q);
  wire        hp   = dma_q[30] & mask_q[31];

  assign irq_o = armed_q & pend;

  always_comb begin
    case (reg_addr_i)
      2'd0:    reg_rdata_o = main_view;
      2'd1:    reg_rdata_o = mask_q;
      2'd2:    reg_rdata_o = dma_q;
      default: reg_rdata_o = 32'(coal_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      dma_q   <= '0;
      mask_q  <= '0;
      coal_q  <= '0;
      left_q  <= '0;
      pre_q   <= '0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      stat_q <= ((stat_q & ~(wr_main ? reg_wdata_i : 32'h0)) | evt_main_i) & ~SUM_BITS;
      dma_q  <= ((dma_q & ~(wr_dma ? reg_wdata_i : 32'h0)) | evt_dma_i) & DMA_IMPL;
      if (wr_mask) mask_q <= reg_wdata_i;
      if (wr_coal) coal_q <= reg_wdata_i[COAL_W-1:0];

      if (!pend) begin
        armed_q <= 1'b0;
        run_q   <= 1'b0;
      end else if (!armed_q) begin
        if (coal_q == '0 || hp) begin
          armed_q <= 1'b1;
          run_q   <= 1'b0;
        end else if (!run_q) begin
          run_q  <= 1'b1;
          left_q <= coal_q;
          pre_q  <= '0;
        end else if (pre_q == PRE_LAST) begin
          pre_q <= '0;
          if (left_q == COAL_W'(1)) begin
            armed_q <= 1'b1;
            run_q   <= 1'b0;
          end else begin
            left_q <= left_q - COAL_W'(1);
          end
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
  parameter int COAL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic [31:0]       evt_main_i,
  input logic              irq_o,
  input logic [31:0]       stat_q,
  input logic [31:0]       dma_q,
  input logic [31:0]       mask_q,
  input logic [COAL_W-1:0] coal_q
);
  localparam logic [31:0] KEEP = 32'h57FF_FFFF;

  logic [31:0] view;
  logic        any_en;
  assign view   = stat_q | {(dma_q[30] | dma_q[17] | dma_q[16]), 1'b0, dma_q[31], 1'b0,
                            (dma_q[1] | dma_q[0]), 27'b0};
  assign any_en = |(view & mask_q);

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_main_i & KEEP)) |=> ((stat_q & $past(evt_main_i & KEEP)) == $past(evt_main_i & KEEP)));

  assert_no_spurious_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == 2'd0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_dma_unimpl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_q & ~32'hC003_0003) == 32'h0);

  assert_irq_needs_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> any_en);

  assert_zero_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_en && coal_q == '0 && !reg_wr_i) |=> irq_o);

  assert_hp_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_q[30] && mask_q[31] && !reg_wr_i) |=> irq_o);

  assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !reg_wr_i) |=> irq_o);
endmodule

bind irq_coalesce_ctrl irq_coalesce_chk #(.COAL_W(COAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .evt_main_i(evt_main_i), .irq_o(irq_o), .stat_q(stat_q), .dma_q(dma_q),
  .mask_q(mask_q), .coal_q(coal_q)
);

// File: tb/test_irq_coalesce_ctrl.sv
`timescale 1ns/1ps
module test_irq_coalesce_ctrl;
  localparam int UNIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_main = '0, evt_dma = '0, wdata = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] rdata;
  logic        irq;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  irq_coalesce_ctrl #(.UNIT_CYCLES(UNIT), .COAL_W(8)) i_irq_coalesce_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_main_i(evt_main), .evt_dma_i(evt_dma),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_stat, m_dma, m_mask;
  int          m_coal, m_wait;
  bit          m_armed;

  function automatic logic [31:0] m_view();
    logic [31:0] v = m_stat;
    if (m_dma[30] || m_dma[17] || m_dma[16]) v[31] = 1'b1;
    if (m_dma[31]) v[29] = 1'b1;
    if (m_dma[1] || m_dma[0]) v[27] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_dma = 0; m_mask = 0; m_coal = 0; m_wait = -1; m_armed = 0;
    end else begin
      bit pend, hp;
      pend = |(m_view() & m_mask);
      hp   = m_dma[30] && m_mask[31];
      if (!pend) begin m_armed = 0; m_wait = -1; end
      else if (m_armed) begin end
      else if (m_coal == 0 || hp) begin m_armed = 1; m_wait = -1; end
      else if (m_wait < 0) m_wait = m_coal * UNIT;
      else begin
        m_wait = m_wait - 1;
        if (m_wait == 0) begin m_armed = 1; m_wait = -1; end
      end
      if (wr && addr == 0) m_stat = m_stat & ~wdata;
      m_stat = (m_stat | evt_main) & 32'h57FF_FFFF;
      if (wr && addr == 2) m_dma = m_dma & ~wdata;
      m_dma = (m_dma | evt_dma) & 32'hC003_0003;
      if (wr && addr == 1) m_mask = wdata;
      if (wr && addr == 3) m_coal = int'(wdata[7:0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp_rd;
      bit          exp_irq;
      case (addr)
        2'd0: exp_rd = m_view();
        2'd1: exp_rd = m_mask;
        2'd2: exp_rd = m_dma;
        default: exp_rd = 32'(m_coal);
      endcase
      exp_irq = m_armed && (|(m_view() & m_mask));
      checks += 2;
      if (rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s (R11 read, addr %0d): actual %h expected %h", cur_req, addr, rdata, exp_rd);
      end
      if (irq !== exp_irq) begin
        errors++;
        $display("FAIL %s irq: actual %b expected %b", cur_req, irq, exp_irq);
      end
    end
  end

  task automatic cyc(input bit w, input logic [1:0] a, input logic [31:0] d,
                     input logic [31:0] em, input logic [31:0] ed);
    #1; wr = w; addr = a; wdata = d; evt_main = em; evt_dma = ed;
    @(negedge clk);
  endtask

  task automatic idle(input logic [1:0] a);
    cyc(0, a, 0, 0, 0);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rise_after(input string req, input int expect_k);
    int k = 0;
    for (int i = 1; i <= 60; i++) begin
      idle(0);
      if (irq && k == 0) k = i;
    end
    chk(req, k, expect_k);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin
      idle(a[1:0]);
      chk("R1", rdata, 0);
    end
    chk("R1", irq, 0);

    cur_req = "R7";
    cyc(1, 1, 32'h8200_00C3, 0, 0);
    cyc(1, 3, 0, 0, 0);
    cyc(0, 0, 0, 32'h1, 0);
    idle(0);
    chk("R7", irq, 1);

    cur_req = "R10";
    idle(0);
    chk("R10 held", irq, 1);
    cyc(1, 0, 32'h1, 0, 0);
    chk("R10 drop", irq, 0);

    cur_req = "R2";
    cyc(1, 1, 32'h0000_0040, 0, 0);
    cyc(0, 0, 0, 32'h0000_0440, 0);
    cyc(1, 0, 32'h0, 0, 0);
    chk("R2 write0", rdata, 32'h0000_0440);
    cyc(1, 0, 32'h0000_0440, 0, 0);
    chk("R2 cleared", rdata, 0);

    cur_req = "R3";
    cyc(0, 0, 0, 32'h0000_0800, 0);
    cyc(1, 0, 32'h0000_0800, 32'h0000_0800, 0);
    chk("R3", rdata, 32'h0000_0800);
    cyc(1, 0, 32'h0000_0800, 0, 0);

    cur_req = "R6";
    cyc(1, 1, 32'h0000_0001, 0, 0);
    cyc(0, 0, 0, 32'h0000_0080, 0);
    repeat (5) idle(0);
    chk("R6 masked", irq, 0);
    cyc(1, 0, 32'h0000_0080, 0, 0);

    cur_req = "R8";
    cyc(1, 1, 32'h8200_0000, 0, 0);
    cyc(1, 3, 32'h0000_0003, 0, 0);
    cyc(0, 0, 0, 32'h0200_0000, 0);
    rise_after("R8", 3 * UNIT + 1);
    cyc(1, 0, 32'h0200_0000, 0, 0);
    chk("R8 ack", irq, 0);

    cur_req = "R5";
    cyc(0, 2, 0, 0, 32'h0001_0000);
    idle(0);
    chk("R5 rx summary", rdata, 32'h8000_0000);
    cyc(1, 0, 32'h8000_0000, 32'h2800_0000, 0);
    chk("R5 write/event ignored", rdata, 32'h8000_0000);
    cyc(0, 2, 0, 0, 32'h8000_0002);
    idle(0);
    chk("R5 all summaries", rdata, 32'hA800_0000);
    cyc(1, 2, 32'hFFFF_FFFF, 0, 0);
    chk("R5 cleared", rdata, 0);

    cur_req = "R4";
    cyc(0, 2, 0, 0, 32'h3FFC_FFFC);
    idle(2);
    chk("R4 unimplemented", rdata, 0);
    cyc(0, 2, 0, 0, 32'hC003_0003);
    idle(2);
    chk("R4 implemented", rdata, 32'hC003_0003);
    cyc(1, 2, 32'hFFFF_FFFF, 0, 0);
    chk("R4 w1c", rdata, 0);

    cur_req = "R9";
    cyc(0, 0, 0, 0, 32'h4000_0000);
    rise_after("R9", 1);
    cyc(1, 2, 32'h4000_0000, 0, 0);

    cur_req = "R11";
    idle(3);
    chk("R11 coal", rdata, 32'h3);
    idle(1);
    chk("R11 mask", rdata, 32'h8200_0000);

    repeat (3) idle(0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule